// File: doc/BRIEF.md
# Reset Cause Control Register

This block holds one 32-bit control word that records why the system last came out of reset. Software can also use it to ask for a soft reset. Software reaches the word through a simple word-addressed register port. Reads are combinational, and a write takes effect at the next clock edge. The word sits at the upper word of a two-word window. The lower word reads as zero and ignores writes.

Five bits at the top of the word are implemented. All other bits read as zero.

| Bit | Meaning | Write behaviour |
|-----|---------|-----------------|
| 31 | Power-up cause | Writing one clears it |
| 30 | Soft power-up request | Takes the written value |
| 29 | Soft warm-reset request | Takes the written value |
| 28 | Button power-up cause | Writing one clears it |
| 27 | Button warm-reset cause | Writing one clears it |

A write that sets either request bit produces a one-cycle pulse on the reset-request output. The pulse appears in the cycle after the write. A separate sequencer, outside this block, acts on that pulse.

The block keeps a one-bit "first reset seen" flag. The true power-up reset sets it and also loads the word with only the power-up cause bit. After that, a reset event from the system reloads the word the same way only while the flag is clear. The flag is cleared by a soft power-up write, so the reset that follows such a write is again recorded as a power-up.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While and right after the synchronous reset `rst`, the word reads 0x8000_0000 and `reset_req` is low.
- R2: Bits 26..0 always read as zero, whatever value is written to them.
- R3: Writing a one to bit 31, 28 or 27 clears that bit. Writing a zero to any of them leaves it unchanged. In this block bits 28 and 27 are never set, so writing one to them leaves them zero.
- R4: On a write to the word, bits 30 and 29 take the written values, either set or cleared.
- R5: A write to the word with bit 30 set clears the first-reset flag. The next `rst_event` then loads the word with exactly 0x8000_0000.
- R6: A write to the word with bit 30 clear and bit 29 set leaves the first-reset flag unchanged.
- R7: An `rst_event` while the first-reset flag is set leaves the word unchanged.
- R8: Word address 0 reads zero, and a write to it changes neither the word nor `reset_req`.
- R9: When an `rst_event` loads the power-up value, it wins over a write to the word in the same cycle. That write still produces its request pulse.
- R10: `reset_req` is high for exactly the one cycle after a write to the word that has bit 30 or bit 29 set. It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| rst_event | input | 1 | Single-cycle system reset event |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (1) | Word address within the window; the word is at address 1 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| reset_req | output | 1 | One-cycle soft reset request |

## Verification
The assertions run on every cycle. They check three kinds of behaviour:
- the write-one-to-clear rule on bit 31 and the direct load of bits 30 and 29;
- the power-up load on a first event, and the hold when nothing touches the word;
- the setting and clearing of the first-reset flag, and that every request pulse was caused by a qualifying write.

Only the bench scenarios can show the multi-step behaviour. One example is a soft power-up write followed by an event that reloads the word, compared with a soft warm write followed by an event that leaves it alone. Another is the same-cycle collision of an event and a write. The last is that the lower word, and the bits outside the cause field, stay zero at the read port.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    localparam int unsigned WORD_W = 32;

    localparam logic [WORD_W-1:0] FIELD_MASK = 32'hF800_0000;
    localparam logic [WORD_W-1:0] POR_WORD   = 32'h8000_0000;

    // Cause field, most significant member at bit 31.
    typedef struct packed {
        logic pwr_on;     // 31: power-up cause (write one to clear)
        logic soft_pwr;   // 30: soft power-up request (direct)
        logic soft_warm;  // 29: soft warm request (direct)
        logic btn_pwr;    // 28: button power-up cause (write one to clear)
        logic btn_warm;   // 27: button warm cause (write one to clear)
    } cause_t;

    localparam int unsigned CAUSE_W = $bits(cause_t);
    localparam int unsigned LOW_W   = WORD_W - CAUSE_W;

    typedef struct packed {
        logic   hit;   // write addressed to the cause word
        cause_t bits;  // masked write data
    } wr_req_t;

    function automatic cause_t word_to_cause(logic [WORD_W-1:0] w);
        return cause_t'(w[WORD_W-1 -: CAUSE_W]);
    endfunction

    function automatic logic [WORD_W-1:0] cause_to_word(cause_t c);
        return {c, {LOW_W{1'b0}}};
    endfunction

    function automatic logic wants_reset(cause_t c);
        return c.soft_pwr | c.soft_warm;
    endfunction

endpackage

// File: rtl/rcc_decode.sv
module rcc_decode
    import rcc_pkg::*;
#(
    parameter int unsigned AW       = 1,
    parameter int unsigned REG_WORD = 1
) (
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output wr_req_t           wr,
    output logic              rd_hit
);
    localparam logic [AW-1:0] REG_ADDR = AW'(REG_WORD);

    logic unused_low_bits;

    assign unused_low_bits = ^wdata[LOW_W-1:0];
    assign rd_hit          = (addr == REG_ADDR);
    assign wr.hit          = wr_en && rd_hit;
    assign wr.bits         = word_to_cause(wdata & FIELD_MASK);
endmodule

// File: rtl/rcc_first_tracker.sv
module rcc_first_tracker (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic arm_clear,
    output logic seen_q,
    output logic load_por
);
    assign load_por = evt && !seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b1;
        end else if (load_por) begin
            seen_q <= 1'b1;
        end else if (arm_clear) begin
            seen_q <= 1'b0;
        end
    end

    a_r5_arm_clears_flag: assert property (@(posedge clk) disable iff (rst)
        (arm_clear && !evt) |=> !seen_q);

    a_r6_flag_held: assert property (@(posedge clk) disable iff (rst)
        (!arm_clear && seen_q) |=> seen_q);

    a_r1_flag_after_reset: assert property (@(posedge clk)
        $past(rst) |-> seen_q);
endmodule

// File: rtl/rcc_cause_reg.sv
module rcc_cause_reg
    import rcc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load_por,
    input  wr_req_t wr,
    output cause_t  cause_q,
    output logic    req_q
);
    cause_t por_cause;
    cause_t cause_d;

    assign por_cause = word_to_cause(POR_WORD);

    always_comb begin
        cause_d = cause_q;
        if (load_por) begin
            cause_d = por_cause;
        end else if (wr.hit) begin
            cause_d.pwr_on    = cause_q.pwr_on   & ~wr.bits.pwr_on;
            cause_d.btn_pwr   = cause_q.btn_pwr  & ~wr.bits.btn_pwr;
            cause_d.btn_warm  = cause_q.btn_warm & ~wr.bits.btn_warm;
            cause_d.soft_pwr  = wr.bits.soft_pwr;
            cause_d.soft_warm = wr.bits.soft_warm;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= por_cause;
            req_q   <= 1'b0;
        end else begin
            cause_q <= cause_d;
            req_q   <= wr.hit && wants_reset(wr.bits);
        end
    end

    a_r1_reset_value: assert property (@(posedge clk)
        $past(rst) |-> (cause_q == por_cause) && !req_q);

    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (wr.hit && wr.bits.pwr_on && !load_por) |=> !cause_q.pwr_on);

    a_r4_direct_bits: assert property (@(posedge clk) disable iff (rst)
        (wr.hit && !load_por) |=>
            (cause_q.soft_pwr == $past(wr.bits.soft_pwr)) &&
            (cause_q.soft_warm == $past(wr.bits.soft_warm)));

    a_r9_por_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_por |=> (cause_q == por_cause));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_por && !wr.hit) |=> $stable(cause_q));
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int unsigned AW       = 1,
    parameter int unsigned REG_WORD = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_event,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              reset_req
);
    wr_req_t wr;
    logic    rd_hit;
    logic    seen_q;
    logic    load_por;
    cause_t  cause_q;

    rcc_decode #(.AW(AW), .REG_WORD(REG_WORD)) u_decode (
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .wr     (wr),
        .rd_hit (rd_hit)
    );

    rcc_first_tracker u_tracker (
        .clk       (clk),
        .rst       (rst),
        .evt       (rst_event),
        .arm_clear (wr.hit && wr.bits.soft_pwr),
        .seen_q    (seen_q),
        .load_por  (load_por)
    );

    rcc_cause_reg u_cause (
        .clk      (clk),
        .rst      (rst),
        .load_por (load_por),
        .wr       (wr),
        .cause_q  (cause_q),
        .req_q    (reset_req)
    );

    assign rdata = rd_hit ? cause_to_word(cause_q) : '0;

    a_r10_req_has_cause: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(wr_en && (addr == AW'(REG_WORD)) &&
                            (wdata[30] || wdata[29])));

    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        rdata[LOW_W-1:0] == '0);
endmodule

// File: tb/rst_cause_ctrl_tb.sv
module rst_cause_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_event = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  addr = 1'b1;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        reset_req;

    int n_checks = 0;
    int n_fail   = 0;

    // behavioural reference state
    logic [31:0] m_word = 32'h8000_0000;
    bit          m_seen = 1'b1;
    bit          m_req  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_cause_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .rst_event (rst_event),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .reset_req (reset_req)
    );

    always @(posedge clk) begin
        logic [31:0] v;
        bit          hit;
        v   = wdata & 32'hF800_0000;
        hit = wr_en && (addr == 1'b1);
        if (rst) begin
            m_word = 32'h8000_0000;
            m_seen = 1'b1;
            m_req  = 1'b0;
        end else begin
            m_req = hit && (v[30] || v[29]);
            if (rst_event && !m_seen) begin
                m_word = 32'h8000_0000;
                m_seen = 1'b1;
            end else if (hit) begin
                m_word        = m_word & ~(v & 32'h9800_0000);
                m_word[30:29] = v[30:29];
                if (v[30]) m_seen = 1'b0;
            end
        end
    end

    // advance one clock, then compare both outputs against the model
    task automatic step(input string tag);
        logic [31:0] exp_rd;
        @(posedge clk);
        #1;
        exp_rd = (addr == 1'b1) ? m_word : 32'h0;
        n_checks++;
        if (rdata !== exp_rd) begin
            n_fail++;
            $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, exp_rd);
        end
        n_checks++;
        if (reset_req !== m_req) begin
            n_fail++;
            $display("FAIL %s reset_req actual=%b expected=%b", tag, reset_req, m_req);
        end
    endtask

    task automatic drive(input bit we, input bit a, input logic [31:0] d, input bit ev);
        wr_en     = we;
        addr      = a;
        wdata     = d;
        rst_event = ev;
    endtask

    task automatic idle(input bit a);
        drive(1'b0, a, 32'h0, 1'b0);
    endtask

    initial begin
        step("R1"); step("R1");
        rst = 1'b0;
        idle(1'b1); step("R1");
        // lower word reads zero, writes ignored
        idle(1'b0); step("R8");
        drive(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0); step("R8");
        idle(1'b1); step("R8");
        // W1C bits 28/27 stay zero, bit 31 untouched by zero
        drive(1'b1, 1'b1, 32'h1800_0000, 1'b0); step("R3");
        idle(1'b1); step("R3");
        // low bits ignored, no request
        drive(1'b1, 1'b1, 32'h07FF_FFFF, 1'b0); step("R2");
        idle(1'b1); step("R10");
        // soft warm request
        drive(1'b1, 1'b1, 32'h2000_0000, 1'b0); step("R6");
        idle(1'b1); step("R10");
        step("R10");
        // event with flag set: unchanged
        drive(1'b0, 1'b1, 32'h0, 1'b1); step("R7");
        idle(1'b1); step("R6");
        // clear direct bits
        drive(1'b1, 1'b1, 32'h0, 1'b0); step("R4");
        idle(1'b1); step("R4");
        // clear power-up cause
        drive(1'b1, 1'b1, 32'h8000_0000, 1'b0); step("R3");
        idle(1'b1); step("R3");
        // soft power-up arms the next event
        drive(1'b1, 1'b1, 32'h4000_0000, 1'b0); step("R5");
        idle(1'b1); step("R10");
        drive(1'b0, 1'b1, 32'h0, 1'b1); step("R5");
        idle(1'b1); step("R5");
        drive(1'b0, 1'b1, 32'h0, 1'b1); step("R7");
        idle(1'b1); step("R7");
        // collision: armed event beats a same-cycle write
        drive(1'b1, 1'b1, 32'h4000_0000, 1'b0); step("R5");
        drive(1'b1, 1'b1, 32'hE000_0000, 1'b1); step("R9");
        idle(1'b1); step("R9");
        // both direct bits, back-to-back requests
        drive(1'b1, 1'b1, 32'h6000_0000, 1'b0); step("R4");
        drive(1'b1, 1'b1, 32'h2000_0000, 1'b0); step("R10");
        idle(1'b1); step("R10");
        step("R10");
        // second power-up reset restores the initial state
        rst = 1'b1; step("R1");
        rst = 1'b0; step("R1");
        drive(1'b0, 1'b1, 32'h0, 1'b1); step("R7");
        idle(1'b1); step("R7");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule